// File: doc/BRIEF.md
# Privileged Instruction Trap Checker

This block sits beside the instruction decoder of a hart that has supervisor, user and virtualized modes. For each decoded system, floating-point or vector instruction, it decides whether the instruction must raise an illegal-instruction exception. The decision uses the current privilege level, the virtualization mode, three trap-control bits (trap-return, timed-wait, trap-translation) and the floating-point and vector context-status fields.

Most checks are purely combinational. A wait-for-interrupt instruction is the exception. Below machine level it may stall only for a bounded number of cycles, so a counter measures how long a stalled wait has lasted. The flag is raised in the cycle that limit is reached. There is no data stream: every pin is a plain level, sampled each cycle by the pipeline stage that issues the instruction.

Top module: `priv_trap_check`

## Requirements
- R1: With `trap_ret` = 1, `virt` = 0 and `priv` = 2'b01 (supervisor), `dec_sret` = 1 sets `illegal` in the same cycle.
- R2: `dec_sret` is never flagged when `trap_ret` = 0, when `virt` = 1, or when `priv` is 2'b11 (machine).
- R3: With `trap_xlat` = 1, `virt` = 0 and `priv` = 2'b01, `dec_xlat` = 1 (access to the translation base register or a virtual-memory fence) sets `illegal` in the same cycle. It is not flagged when `trap_xlat` = 0, `virt` = 1, or `priv` = 2'b11.
- R4: `dec_fp` = 1 sets `illegal` in the same cycle exactly when `fp_state` = 2'b00.
- R5: `dec_vec` = 1 sets `illegal` in the same cycle exactly when `vec_state` = 2'b00.
- R6: A wait at `priv` = 2'b11 never sets `illegal`, however long it stalls.
- R7: A wait at `priv` = 2'b00 (user), held with `dec_wfi` = 1 and `wfi_wait` = 1, sets `illegal` in the cycle `WAIT_CYCLES` cycles after the first stalled cycle. The flag stays set while the stall continues.
- R8: At `priv` = 2'b01 with `timed_wait` = 0, a wait never sets `illegal`. With `timed_wait` = 1 it follows R7's timing.
- R9: `wake` = 1 clears the wait counter and keeps `illegal` low in that cycle. A later stall counts again from zero.
- R10: Dropping `wfi_wait` or `dec_wfi` for one cycle restarts the wait count.
- R11: After reset, with no decode flag set, `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt | input | 1 | Virtualization mode active |
| trap_ret | input | 1 | Trap supervisor return control bit |
| timed_wait | input | 1 | Timed wait control bit |
| trap_xlat | input | 1 | Trap translation management control bit |
| fp_state | input | 2 | Floating-point context status, 00 = off |
| vec_state | input | 2 | Vector context status, 00 = off |
| dec_sret | input | 1 | Decoded supervisor return |
| dec_wfi | input | 1 | Decoded wait-for-interrupt |
| dec_xlat | input | 1 | Decoded translation register access or VM fence |
| dec_fp | input | 1 | Decoded floating-point instruction |
| dec_vec | input | 1 | Decoded vector instruction |
| wfi_wait | input | 1 | The wait is still stalled |
| wake | input | 1 | Interrupt wakes the core |
| illegal | output | 1 | Illegal-instruction decision |

## Verification
The return, translation, floating-point and vector results are combinational. The bench drives them after a falling edge and samples half a period later, in the same cycle. The wait result lags its stimulus by exactly `WAIT_CYCLES` rising edges. The bench holds the stall, counts falling edges from the first stalled cycle, and expects the flag low on every one of them until the edge at index `WAIT_CYCLES`. Wake and restart cases are sampled in the cycle of the interruption, and then again along a fresh count.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
  localparam logic [1:0] LVL_USER  = 2'b00;
  localparam logic [1:0] LVL_SUPER = 2'b01;
  localparam logic [1:0] LVL_MACH  = 2'b11;
  localparam logic [1:0] CTX_OFF   = 2'b00;

  typedef struct packed {
    logic ret_bad;
    logic xlat_bad;
    logic fp_bad;
    logic vec_bad;
  } rule_hits_t;
endpackage

// File: rtl/pt_static_rules.sv
module pt_static_rules
  import priv_trap_pkg::*;
#(
  parameter bit HAS_VECTOR = 1'b1
) (
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       trap_ret,
  input  logic       trap_xlat,
  input  logic [1:0] fp_state,
  input  logic [1:0] vec_state,
  input  logic       dec_sret,
  input  logic       dec_xlat,
  input  logic       dec_fp,
  input  logic       dec_vec,
  output rule_hits_t hits
);
  logic host_super;
  assign host_super = (priv == LVL_SUPER) && !virt;

  always_comb begin
    hits.ret_bad  = dec_sret && trap_ret && host_super;
    hits.xlat_bad = dec_xlat && trap_xlat && host_super;
    hits.fp_bad   = dec_fp && (fp_state == CTX_OFF);
  end

  generate
    if (HAS_VECTOR) begin : g_vec
      assign hits.vec_bad = dec_vec && (vec_state == CTX_OFF);
    end else begin : g_novec
      logic unused_vec;
      assign unused_vec   = ^vec_state;
      assign hits.vec_bad = dec_vec;
    end
  endgenerate
endmodule

// File: rtl/pt_wait_timer.sv
module pt_wait_timer
  import priv_trap_pkg::*;
#(
  parameter int WAIT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] priv,
  input  logic       timed_wait,
  input  logic       dec_wfi,
  input  logic       wfi_wait,
  input  logic       wake,
  output logic       expired
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_CYCLES);

  logic             bounded;
  logic             counting;
  logic [CNT_W-1:0] cnt_q;

  // Bounded below machine level; supervisor only when the timed-wait bit is set.
  assign bounded  = (priv != LVL_MACH) && (timed_wait || (priv != LVL_SUPER));
  assign counting = dec_wfi && wfi_wait && !wake && bounded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!counting)     cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = counting && (cnt_q == LIMIT);
endmodule

// File: rtl/priv_trap_check.sv
module priv_trap_check
  import priv_trap_pkg::*;
#(
  parameter int WAIT_CYCLES = 16,
  parameter bit HAS_VECTOR  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       trap_ret,
  input  logic       timed_wait,
  input  logic       trap_xlat,
  input  logic [1:0] fp_state,
  input  logic [1:0] vec_state,
  input  logic       dec_sret,
  input  logic       dec_wfi,
  input  logic       dec_xlat,
  input  logic       dec_fp,
  input  logic       dec_vec,
  input  logic       wfi_wait,
  input  logic       wake,
  output logic       illegal
);
  rule_hits_t hits;
  logic       wait_over;

  pt_static_rules #(.HAS_VECTOR(HAS_VECTOR)) u_rules (
    .priv(priv), .virt(virt), .trap_ret(trap_ret), .trap_xlat(trap_xlat),
    .fp_state(fp_state), .vec_state(vec_state), .dec_sret(dec_sret),
    .dec_xlat(dec_xlat), .dec_fp(dec_fp), .dec_vec(dec_vec), .hits(hits)
  );

  pt_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .priv(priv), .timed_wait(timed_wait),
    .dec_wfi(dec_wfi), .wfi_wait(wfi_wait), .wake(wake), .expired(wait_over)
  );

  assign illegal = (|hits) || wait_over;
endmodule

// File: rtl/priv_trap_check_chk.sv
module priv_trap_check_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] priv,
  input logic       virt,
  input logic       trap_ret,
  input logic [1:0] fp_state,
  input logic [1:0] vec_state,
  input logic       dec_sret,
  input logic       dec_wfi,
  input logic       dec_xlat,
  input logic       dec_fp,
  input logic       dec_vec,
  input logic       wfi_wait,
  input logic       wake,
  input logic       illegal
);
  logic only_wfi;
  assign only_wfi = dec_wfi && !dec_sret && !dec_xlat && !dec_fp && !dec_vec;

  // R1
  sret_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_sret && trap_ret && !virt && priv == 2'b01) |-> illegal);
  // R4
  fp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fp && fp_state == 2'b00) |-> illegal);
  // R5
  vec_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vec && vec_state == 2'b00) |-> illegal);
  // R6
  mach_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_wfi && priv == 2'b11) |-> !illegal);
  // R9
  wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_wfi && wake) |-> !illegal);
  // R7
  wait_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(illegal) && only_wfi) |-> $past(dec_wfi && wfi_wait && !wake));
endmodule

bind priv_trap_check priv_trap_check_chk u_chk (
  .clk(clk), .rst_n(rst_n), .priv(priv), .virt(virt), .trap_ret(trap_ret),
  .fp_state(fp_state), .vec_state(vec_state), .dec_sret(dec_sret),
  .dec_wfi(dec_wfi), .dec_xlat(dec_xlat), .dec_fp(dec_fp), .dec_vec(dec_vec),
  .wfi_wait(wfi_wait), .wake(wake), .illegal(illegal)
);

// File: tb/sim_priv_trap_check.sv
module sim_priv_trap_check;
  localparam int WAIT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] priv = '0, fp_state = '0, vec_state = '0;
  logic virt = 0, trap_ret = 0, timed_wait = 0, trap_xlat = 0;
  logic dec_sret = 0, dec_wfi = 0, dec_xlat = 0, dec_fp = 0, dec_vec = 0;
  logic wfi_wait = 0, wake = 0, illegal;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  priv_trap_check #(.WAIT_CYCLES(WAIT)) u0 (.*);

  // {priv,virt,trap_ret,timed_wait,trap_xlat,fp,vec,sret,wfi,xlat,fp_i,vec_i,expect}
  localparam logic [15:0] VEC [14] = '{
    16'b01_0_1_0_0_01_01_1_0_0_0_0_1, // R1 sret S tsr
    16'b01_1_1_0_0_01_01_1_0_0_0_0_0, // R2 virtual
    16'b01_0_0_0_0_01_01_1_0_0_0_0_0, // R2 tsr off
    16'b11_0_1_0_0_01_01_1_0_0_0_0_0, // R2 machine
    16'b01_0_0_0_1_01_01_0_0_1_0_0_1, // R3 tvm S
    16'b01_1_0_0_1_01_01_0_0_1_0_0_0, // R3 virtual
    16'b11_0_0_0_1_01_01_0_0_1_0_0_0, // R3 machine
    16'b01_0_0_0_0_01_01_0_0_1_0_0_0, // R3 tvm off
    16'b11_0_0_0_0_00_01_0_0_0_1_0_1, // R4 fp off
    16'b00_0_0_0_0_11_01_0_0_0_1_0_0, // R4 fp dirty
    16'b00_0_0_0_0_01_00_0_0_0_0_1_1, // R5 vec off
    16'b01_0_0_0_0_01_10_0_0_0_0_1_0, // R5 vec clean
    16'b00_0_0_1_0_01_01_0_1_0_0_0_0, // R7 wfi not stalled
    16'b00_0_0_0_0_00_00_0_0_0_0_0_0  // R11 idle
  };

  task automatic check(input logic exp, input string req);
    checks++;
    if (illegal !== exp) begin
      errors++;
      $display("FAIL %s: illegal=%b expected=%b", req, illegal, exp);
    end
  endtask

  task automatic clear_in();
    {virt, trap_ret, timed_wait, trap_xlat} = '0;
    {dec_sret, dec_wfi, dec_xlat, dec_fp, dec_vec, wfi_wait, wake} = '0;
    priv = 2'b00; fp_state = 2'b01; vec_state = 2'b01;
  endtask

  // stall for WAIT+1 cycles, expecting flag only at index WAIT when may_trap
  task automatic stall_run(input logic [1:0] p, input logic tw, input logic may_trap, input string req);
    @(negedge clk); clear_in(); #5;
    @(negedge clk); priv = p; timed_wait = tw; dec_wfi = 1; wfi_wait = 1;
    for (int i = 0; i <= WAIT; i++) begin
      #5; check(may_trap && (i == WAIT), req);
      @(negedge clk);
    end
    #5; check(may_trap, req);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_in(); fp_state = 2'b00;
    #5; check(1'b0, "R11 reset");
    repeat (2) @(negedge clk);
    rst_n = 1;
    foreach (VEC[k]) begin
      @(negedge clk);
      {priv, virt, trap_ret, timed_wait, trap_xlat, fp_state, vec_state,
       dec_sret, dec_wfi, dec_xlat, dec_fp, dec_vec} = VEC[k][15:1];
      wfi_wait = 0; wake = 0;
      #5; check(VEC[k][0], $sformatf("vector %0d", k));
    end
    stall_run(2'b00, 1'b0, 1'b1, "R7 user wait");
    stall_run(2'b11, 1'b1, 1'b0, "R6 machine wait");
    stall_run(2'b01, 1'b0, 1'b0, "R8 super tw0");
    stall_run(2'b01, 1'b1, 1'b1, "R8 super tw1");
    // R9: wake mid-count restarts count
    @(negedge clk); clear_in(); #5;
    @(negedge clk); dec_wfi = 1; wfi_wait = 1;
    repeat (WAIT - 2) @(negedge clk);
    wake = 1; #5; check(1'b0, "R9 wake cycle");
    @(negedge clk); wake = 0;
    for (int i = 0; i <= WAIT; i++) begin
      #5; check(i == WAIT, "R9 recount");
      @(negedge clk);
    end
    // R10: one-cycle gap restarts
    wfi_wait = 0; #5; check(1'b0, "R10 gap");
    @(negedge clk); wfi_wait = 1;
    for (int i = 0; i <= WAIT; i++) begin
      #5; check(i == WAIT, "R10 recount");
      @(negedge clk);
    end
    clear_in();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule